// File: doc/BRIEF.md
# Serial EEPROM Byte Fetch Controller

This controller fetches a run of consecutive bytes from a small serial EEPROM over a four-wire link: an active-low select, a serial clock, a data line toward the memory and a data line back from it. A requester gives a start address and a byte count with a one-cycle start strobe. The controller then fetches each byte in a frame of its own, and hands each result back with a one-cycle valid strobe. When the run ends it pulses done.

Every byte costs a full frame: select goes low, the read opcode 0x03 goes out, then the 8-bit address, then eight clocks bring the byte back. Select then returns high for one half-period and the address steps up by one. A separate request kind fetches the memory's status byte, using opcode 0x05 with no address phase. After reset, and before any frame, the controller runs a short wake pattern on the clock with select held high.

Top module: `spi_eeprom_reader`

## Requirements
- R1: During reset and whenever busy is low, spi_cs_n is high; during reset spi_sck is low and byte_valid and done are low.
- R2: After reset the block is busy while it gives exactly two spi_sck high pulses with spi_cs_n high. No frame starts before that ends, and busy then drops.
- R3: In a byte read frame, spi_cs_n falls with spi_sck low and spi_mosi low. The memory sees, on the rising spi_sck edges, the 8 bits 0x03 and then the 8 address bits, each most significant bit first.
- R4: After the address, eight more spi_sck cycles run. spi_miso is sampled late in each low phase, most significant bit first, and the byte appears on byte_data with byte_valid high for exactly one cycle.
- R5: When a frame ends, spi_cs_n rises with spi_sck and spi_mosi low. Between frames of one run, spi_cs_n stays high for exactly HALF_CYC cycles.
- R6: A run with count N > 0 produces exactly N frames and N bytes, at addresses start_addr, start_addr+1 and so on, wrapping from 0xFF to 0x00.
- R7: done is a one-cycle pulse after the last frame, and busy is low in the cycle done is high.
- R8: A start with count 0 and status_req low gives a done pulse in the next cycle with no frame and with busy staying low.
- R9: A start that arrives while busy is high has no effect on the run in progress or after it.
- R10: A start with status_req high sends opcode 0x05, then exactly eight data clocks with no address phase. It returns one byte, whatever count is.
- R11: Every spi_sck high phase lasts exactly HALF_CYC system clock cycles (default 4).
- R12: A start given in the cycle that done is high is accepted, and busy is high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request strobe |
| status_req | input | 1 | With start: fetch the status byte instead of a data run |
| start_addr | input | 8 | First byte address of the run |
| count | input | 8 | Number of bytes to fetch |
| busy | output | 1 | Wake pattern or a run is in progress |
| byte_valid | output | 1 | One-cycle strobe: byte_data holds a fetched byte |
| byte_data | output | 8 | Last byte fetched |
| done | output | 1 | One-cycle pulse at the end of a run |
| spi_cs_n | output | 1 | Memory select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data toward the memory |
| spi_miso | input | 1 | Serial data from the memory |

## Verification
The end of one run and the acceptance of the next can fall in the same cycle. Done is high and busy is already low, so a start in that cycle must open a new run rather than be dropped as one that arrives while busy. The bench finishes one run, raises start in the very cycle it sees done, and then expects busy high one cycle later and the new byte at its own address. A start raised in the middle of a run is the opposite case, and the bench judges it by the frame count and by the byte stream alone.

// File: rtl/eeprom_rd_pkg.sv
// Package: shared state type and opcodes for the serial EEPROM fetch controller.
// Assumes 8-bit opcodes shifted most significant bit first.
package eeprom_rd_pkg;

    typedef enum logic [1:0] {
        ST_WAKE  = 2'd0,
        ST_IDLE  = 2'd1,
        ST_FRAME = 2'd2,
        ST_GAP   = 2'd3
    } seq_state_t;

    localparam int          CMD_W   = 8;
    localparam logic [7:0]  OP_READ = 8'h03;
    localparam logic [7:0]  OP_STAT = 8'h05;

endpackage

// File: rtl/eeprom_half_timer.sv
// Module: half-period timer. It pulses tick on the last system cycle of each
// serial clock half-period while run is high. It holds at zero while run is
// low, so a half-period always starts in full when run rises.
module eeprom_half_timer #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    generate
        if (HALF_CYC <= 1) begin : g_every
            logic unused_rst;
            assign unused_rst = rst_n ^ clk;
            assign tick = run;
        end else begin : g_count
            localparam int TW = $clog2(HALF_CYC);
            localparam logic [TW-1:0] LAST = TW'(HALF_CYC - 1);
            logic [TW-1:0] cnt_q;

            assign tick = run && (cnt_q == LAST);

            // Count system cycles inside the current half-period
            always_ff @(posedge clk) begin
                if (!rst_n)      cnt_q <= '0;
                else if (!run)   cnt_q <= '0;
                else if (tick)   cnt_q <= '0;
                else             cnt_q <= cnt_q + 1'b1;
            end
        end
    endgenerate

endmodule

// File: rtl/eeprom_bit_shifter.sv
// Module: the two shift registers of a frame. The outgoing word (opcode and
// address) leaves most significant bit first and fills with zeros behind it.
// Incoming bits enter at the bottom. It assumes the sequencer never asks to
// load, shift or sample outside a frame.
module eeprom_bit_shifter #(
    parameter int TX_W = 16,
    parameter int RX_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [TX_W-1:0] load_word,
    input  logic            shift_tx,
    input  logic            sample,
    input  logic            miso,
    output logic            mosi_bit,
    output logic [RX_W-1:0] rx_word
);

    logic [TX_W-1:0] tx_q;
    logic [RX_W-1:0] rx_q;

    // Outgoing register: load a fresh frame word or advance one bit
    always_ff @(posedge clk) begin
        if (!rst_n)        tx_q <= '0;
        else if (load)     tx_q <= load_word;
        else if (shift_tx) tx_q <= {tx_q[TX_W-2:0], 1'b0};
    end

    // Incoming register: collect one sampled bit at a time
    always_ff @(posedge clk) begin
        if (!rst_n)      rx_q <= '0;
        else if (sample) rx_q <= {rx_q[RX_W-2:0], miso};
    end

    assign mosi_bit = tx_q[TX_W-1];
    assign rx_word  = rx_q;

endmodule

// File: rtl/spi_eeprom_reader.sv
// Module: serial EEPROM sequential byte fetch controller (top).
// After reset it runs a wake pattern of WAKE_PULSES clock pulses with select
// high. Then it serves requests: each byte is a full frame made of an opcode,
// an address and eight data clocks, with one gap half-period between frames.
// A status request sends one frame with opcode 0x05 and no address.
// It assumes that spi_miso changes on falling spi_sck and is stable by the end
// of the low half-period.
module spi_eeprom_reader
    import eeprom_rd_pkg::*;
#(
    parameter int HALF_CYC    = 4,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int CNT_W       = 8,
    parameter int WAKE_PULSES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              status_req,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  count,
    output logic              busy,
    output logic              byte_valid,
    output logic [DATA_W-1:0] byte_data,
    output logic              done,
    output logic              spi_cs_n,
    output logic              spi_sck,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    localparam int TX_W        = CMD_W + ADDR_W;
    localparam int FRAME_BITS  = CMD_W + ADDR_W + DATA_W;
    localparam int STAT_BITS   = CMD_W + DATA_W;
    localparam int BIT_W       = $clog2(FRAME_BITS + 1);
    localparam int WAKE_HALVES = 2 * WAKE_PULSES + 1;
    localparam int WK_W        = $clog2(WAKE_HALVES + 1);

    localparam logic [BIT_W-1:0] RD_LAST   = BIT_W'(FRAME_BITS - 1);
    localparam logic [BIT_W-1:0] ST_LAST   = BIT_W'(STAT_BITS - 1);
    localparam logic [BIT_W-1:0] RD_DATA0  = BIT_W'(CMD_W + ADDR_W);
    localparam logic [BIT_W-1:0] ST_DATA0  = BIT_W'(CMD_W);
    localparam logic [WK_W-1:0]  WAKE_LAST = WK_W'(WAKE_HALVES - 1);

    seq_state_t        state_q;
    logic              half_q;
    logic [BIT_W-1:0]  bit_q;
    logic [WK_W-1:0]   wake_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  left_q;
    logic              stat_q;
    logic              valid_q;
    logic              done_q;

    logic              tick;
    logic              last_bit;
    logic              data_phase;
    logic              load;
    logic [TX_W-1:0]   load_word;
    logic              shift_tx;
    logic              sample;
    logic              mosi_bit;
    logic [DATA_W-1:0] rx_word;

    eeprom_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q != ST_IDLE),
        .tick  (tick)
    );

    // Frame position decode: last bit of the frame and start of the data phase
    always_comb begin
        last_bit   = (bit_q == (stat_q ? ST_LAST : RD_LAST));
        data_phase = (bit_q >= (stat_q ? ST_DATA0 : RD_DATA0));
    end

    // Shifter control: load at frame open, shift at each falling edge, sample late in the low half
    always_comb begin
        load = ((state_q == ST_IDLE) && start && (status_req || (count != '0)))
            || ((state_q == ST_GAP) && tick && (left_q != CNT_W'(1)));
        if (state_q == ST_IDLE)
            load_word = status_req ? {OP_STAT, {ADDR_W{1'b0}}} : {OP_READ, start_addr};
        else
            load_word = {OP_READ, addr_q + ADDR_W'(1)};
        shift_tx = (state_q == ST_FRAME) && tick && half_q;
        sample   = (state_q == ST_FRAME) && tick && !half_q && data_phase;
    end

    eeprom_bit_shifter #(.TX_W(TX_W), .RX_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_word (load_word),
        .shift_tx  (shift_tx),
        .sample    (sample),
        .miso      (spi_miso),
        .mosi_bit  (mosi_bit),
        .rx_word   (rx_word)
    );

    // Sequencer: wake pattern, request intake, frame bit stepping and gap handling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAKE;
            half_q  <= 1'b0;
            bit_q   <= '0;
            wake_q  <= '0;
            addr_q  <= '0;
            left_q  <= '0;
            stat_q  <= 1'b0;
            valid_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            done_q  <= 1'b0;
            case (state_q)
                ST_WAKE: begin
                    if (tick) begin
                        if (wake_q == WAKE_LAST) state_q <= ST_IDLE;
                        else                     wake_q  <= wake_q + 1'b1;
                    end
                end
                ST_IDLE: begin
                    if (start) begin
                        if (status_req) begin
                            stat_q  <= 1'b1;
                            left_q  <= CNT_W'(1);
                            bit_q   <= '0;
                            half_q  <= 1'b0;
                            state_q <= ST_FRAME;
                        end else if (count == '0) begin
                            done_q  <= 1'b1;
                        end else begin
                            stat_q  <= 1'b0;
                            left_q  <= count;
                            addr_q  <= start_addr;
                            bit_q   <= '0;
                            half_q  <= 1'b0;
                            state_q <= ST_FRAME;
                        end
                    end
                end
                ST_FRAME: begin
                    if (tick) begin
                        if (!half_q) begin
                            half_q <= 1'b1;
                        end else begin
                            half_q <= 1'b0;
                            if (last_bit) begin
                                state_q <= ST_GAP;
                                valid_q <= 1'b1;
                            end else begin
                                bit_q <= bit_q + 1'b1;
                            end
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (left_q == CNT_W'(1)) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            left_q  <= left_q - 1'b1;
                            addr_q  <= addr_q + ADDR_W'(1);
                            bit_q   <= '0;
                            state_q <= ST_FRAME;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (state_q != ST_IDLE);
    assign byte_valid = valid_q;
    assign byte_data  = rx_word;
    assign done       = done_q;
    assign spi_cs_n   = (state_q != ST_FRAME);
    assign spi_sck    = ((state_q == ST_WAKE) && wake_q[0]) || ((state_q == ST_FRAME) && half_q);
    assign spi_mosi   = (state_q == ST_FRAME) && mosi_bit;

endmodule

// File: rtl/spi_eeprom_reader_chk.sv
// Module: protocol checker for spi_eeprom_reader, bound to every instance.
// It watches only the top-level ports.
module spi_eeprom_reader_chk #(
    parameter int HALF_CYC = 4
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic byte_valid,
    input logic done,
    input logic spi_cs_n,
    input logic spi_sck,
    input logic spi_mosi
);

    localparam int HW = $clog2(HALF_CYC + 1) + 1;
    logic [HW-1:0] hi_cnt;

    // Count system cycles spent with spi_sck high
    always_ff @(posedge clk) begin
        if (!rst_n)       hi_cnt <= '0;
        else if (spi_sck) hi_cnt <= hi_cnt + 1'b1;
        else              hi_cnt <= '0;
    end

    p_idle_cs_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> spi_cs_n);

    p_cs_fall_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> (!spi_sck && !spi_mosi));

    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);

    p_cs_rise_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> (!spi_sck && !spi_mosi));

    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !byte_valid));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_high_half_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_sck) |-> (hi_cnt == HW'(HALF_CYC)));

endmodule

bind spi_eeprom_reader spi_eeprom_reader_chk #(.HALF_CYC(HALF_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .byte_valid (byte_valid),
    .done       (done),
    .spi_cs_n   (spi_cs_n),
    .spi_sck    (spi_sck),
    .spi_mosi   (spi_mosi)
);

// File: tb/spi_eeprom_reader_tb.sv
`timescale 1ns/1ps
module spi_eeprom_reader_tb;

    localparam int         HALF     = 4;
    localparam logic [7:0] STAT_VAL = 8'hA6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       status_req = 1'b0;
    logic [7:0] start_addr = '0;
    logic [7:0] count = '0;
    logic       busy, byte_valid, done, spi_cs_n, spi_sck, spi_mosi;
    logic [7:0] byte_data;
    logic       spi_miso = 1'b0;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    spi_eeprom_reader #(.HALF_CYC(HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .status_req(status_req),
        .start_addr(start_addr), .count(count), .busy(busy),
        .byte_valid(byte_valid), .byte_data(byte_data), .done(done),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_val(input logic [7:0] a);
        return 8'(a * 8'd37) ^ 8'h5A;
    endfunction

    // ---------------- memory model ----------------
    int         rise_cnt = 0;
    int         wake_rises = 0;
    int         cs_falls = 0;
    int         out_idx = 0;
    logic [7:0] in_sh = '0;
    logic [7:0] cmd_rx = '0;
    logic [7:0] addr_rx = '0;
    logic [7:0] out_byte = '0;

    always @(negedge spi_cs_n) begin
        rise_cnt = 0;
        out_idx  = 0;
        cmd_rx   = '0;
        cs_falls++;
    end

    always @(posedge spi_sck) begin
        if (!spi_cs_n) begin
            in_sh = {in_sh[6:0], spi_mosi};
            rise_cnt++;
            if (rise_cnt == 8)  cmd_rx  = in_sh;
            if (rise_cnt == 16 && cmd_rx == 8'h03) addr_rx = in_sh;
        end else begin
            wake_rises++;
        end
    end

    always @(negedge spi_sck) begin
        if (!spi_cs_n && out_idx < 8 &&
            ((cmd_rx == 8'h03 && rise_cnt >= 16) || (cmd_rx == 8'h05 && rise_cnt >= 8))) begin
            if (out_idx == 0) out_byte = (cmd_rx == 8'h03) ? mem_val(addr_rx) : STAT_VAL;
            spi_miso = out_byte[7 - out_idx];
            out_idx++;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct packed {
        logic [7:0] cmd;
        logic [7:0] addr;
        logic [7:0] data;
        logic [7:0] rises;
    } exp_t;
    exp_t exp_q[$];

    // Monitor: pop expected bytes and compare against each byte_valid strobe
    always @(negedge clk) begin
        if (rst_n && byte_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected byte", byte_data, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(byte_data == e.data, "R4 byte_data", byte_data, e.data);
                chk(cmd_rx == e.cmd, "R3/R10 opcode seen by memory", cmd_rx, e.cmd);
                chk(rise_cnt == int'(e.rises), "R10/R4 clocks per frame", rise_cnt, e.rises);
                if (e.cmd == 8'h03)
                    chk(addr_rx == e.addr, "R6 frame address", addr_rx, e.addr);
            end
        end
    end

    // Line monitor: sck high run length, gap length, lines at frame close
    int   hi_run = 0;
    int   bad_hi = 0;
    int   hi_seen = 0;
    int   cs_hi_run = 0;
    int   min_gap = 1000000;
    logic cs_prev = 1'b1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (spi_sck) hi_run++;
            else if (hi_run > 0) begin
                hi_seen++;
                if (hi_run != HALF) bad_hi++;
                hi_run = 0;
            end
            if (spi_cs_n && !cs_prev)
                chk(!spi_sck && !spi_mosi, "R5 lines low at frame close", {spi_sck, spi_mosi}, 0);
            if (!spi_cs_n && cs_prev && cs_falls > 1 && cs_hi_run < min_gap)
                min_gap = cs_hi_run;
            if (spi_cs_n) cs_hi_run++;
            else          cs_hi_run = 0;
            cs_prev = spi_cs_n;
        end
    end

    // ---------------- driver ----------------
    task automatic issue(input logic [7:0] a, input logic [7:0] n, input logic st);
        if (st) exp_q.push_back({8'h05, 8'h00, STAT_VAL, 8'd16});
        else for (int i = 0; i < n; i++)
            exp_q.push_back({8'h03, 8'(a + i), mem_val(8'(a + i)), 8'd24});
        start = 1'b1; status_req = st; start_addr = a; count = n;
        @(negedge clk);
        start = 1'b0; status_req = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        chk(!busy, "R7 busy low with done", busy, 0);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int f0;
        repeat (3) @(negedge clk);
        chk(spi_cs_n && !spi_sck && !byte_valid && !done, "R1 reset state",
            {spi_cs_n, spi_sck, byte_valid, done}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy, "R2 busy during wake", busy, 1);
        while (busy) @(negedge clk);
        chk(wake_rises == 2, "R2 wake pulses", wake_rises, 2);
        chk(cs_falls == 0, "R2 no frame during wake", cs_falls, 0);
        chk(spi_cs_n, "R1 select high when idle", spi_cs_n, 1);

        // three-byte run
        f0 = cs_falls;
        issue(8'h10, 8'd3, 1'b0);
        wait_done();
        @(negedge clk);
        chk(!done, "R7 done is one cycle", done, 0);
        chk(cs_falls - f0 == 3, "R6 frame count", cs_falls - f0, 3);
        chk(exp_q.size() == 0, "R6 byte count", exp_q.size(), 0);

        // address wrap
        f0 = cs_falls;
        issue(8'hFE, 8'd3, 1'b0);
        wait_done();
        chk(cs_falls - f0 == 3 && exp_q.size() == 0, "R6 wrap run", cs_falls - f0, 3);

        // zero count
        repeat (3) @(negedge clk);
        f0 = cs_falls;
        start = 1'b1; count = 8'd0; start_addr = 8'h55;
        @(negedge clk);
        start = 1'b0;
        chk(done && !busy, "R8 immediate done", {done, busy}, 2'b10);
        repeat (20) @(negedge clk);
        chk(cs_falls == f0 && !busy, "R8 no frame", cs_falls - f0, 0);

        // start while busy is ignored
        f0 = cs_falls;
        issue(8'h40, 8'd2, 1'b0);
        repeat (50) @(negedge clk);
        start = 1'b1; start_addr = 8'h80; count = 8'd5;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        repeat (40) @(negedge clk);
        chk(cs_falls - f0 == 2 && !busy, "R9 busy start ignored", cs_falls - f0, 2);
        chk(exp_q.size() == 0, "R9 queue drained", exp_q.size(), 0);

        // status read, count ignored
        f0 = cs_falls;
        issue(8'h00, 8'd7, 1'b1);
        wait_done();
        chk(cs_falls - f0 == 1 && exp_q.size() == 0, "R10 single status frame", cs_falls - f0, 1);

        // back-to-back: start in the done cycle
        issue(8'h20, 8'd1, 1'b0);
        wait_done();
        issue(8'h30, 8'd1, 1'b0);
        chk(busy, "R12 start accepted in done cycle", busy, 1);
        wait_done();
        @(negedge clk);
        chk(exp_q.size() == 0, "R12 both bytes delivered", exp_q.size(), 0);

        chk(bad_hi == 0 && hi_seen > 0, "R11 sck high length", bad_hi, 0);
        chk(min_gap == HALF, "R5 gap between frames", min_gap, HALF);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule